// File: doc/BRIEF.md
# Column Burst Address Generator

This block walks the column addresses of one memory burst. A start strobe captures a start column and the burst settings: a length code, an ordering choice (linear wrap or XOR wrap) and a row-wrap option. From the next cycle on, the block presents one column address per beat on an output stream. It keeps going until the programmed number of beats has been accepted. In row-wrap mode it runs without end until a stop request arrives.

The output is a stream. `col_valid` marks a presented address, and the consumer accepts it by holding `beat_ready` high at a clock edge. A low `beat_ready` is the back-pressure path and also the clock-suspend hold: while it is low, the presented address, its last-beat flag and the beat position all stay frozen. The block needs no input handshake. `start` and `stop` act on every edge they are sampled on. A new `start` restarts the walk from its own column even in the middle of a burst, and it wins over `stop`. `col_last` marks the final address of a bounded burst. `burst_done` pulses for one cycle after that final beat is accepted.

Top module: `colburst_agen`

## Requirements
- R1: While reset is held and directly after it, `col_valid`, `col_last` and `burst_done` are 0.
- R2: A `start` sampled at an edge makes `col_valid` 1 after that edge, with `col_addr` equal to the `start_col` sampled at the same edge.
- R3: With `interleave`=0 and `full_page`=0, beat k presents the start column with its low log2(BL) bits replaced by (those bits + k) mod BL. The upper bits stay unchanged. `burst_len` codes 0, 1, 2 and 3 select BL = 1, 2, 4 and 8.
- R4: With `interleave`=1 and `full_page`=0, beat k presents the start column with k XORed into its low log2(BL) bits.
- R5: `col_last` is 1 exactly while the beat with index BL-1 of a bounded burst is presented, and at no other time.
- R6: When the final beat of a bounded burst is accepted with no `start` or `stop` at that edge, `col_valid` falls after that edge and `burst_done` is 1 for exactly that one cycle.
- R7: While `col_valid`=1 and `beat_ready`=0, with no `start` or `stop`, the next cycle shows the same `col_addr` and `col_last`, and no beat is skipped.
- R8: With `full_page`=1, beats run (start + k) mod 256 and `interleave` has no effect. `col_last` and `burst_done` never assert.
- R9: A `stop` without `start` clears `col_valid` after that edge and produces no `burst_done`.
- R10: A `start` during a running burst discards the rest of that burst and restarts at beat 0 of the new settings.
- R11: `start_col`, `burst_len`, `interleave` and `full_page` are sampled only with `start`. Changing them mid-burst has no effect on the addresses presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the settings below |
| start_col | input | 8 | First column of the burst |
| burst_len | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 beats |
| interleave | input | 1 | 1 selects XOR wrap order |
| full_page | input | 1 | 1 runs the whole row until stopped |
| stop | input | 1 | End the running burst |
| beat_ready | input | 1 | Accept or advance enable for the presented beat |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | 8 | Presented column address |
| col_last | output | 1 | Presented beat is the final one of a bounded burst |
| burst_done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The first address appears one edge after `start`. Each later address appears one edge after the previous one was accepted. `burst_done` is due one edge after the final accepted beat, and `col_valid` drops on that same edge. A `stop` or a restart takes effect on the edge that samples it. The bench drives inputs just after a rising edge and checks on the falling edge. At that point a scoreboard pops one expected address and last flag for each accepted beat, so stalled cycles are skipped naturally. Done, stop and restart outcomes are checked one cycle after the edge on which they are due.

// File: rtl/colburst_pkg.sv
package colburst_pkg;
  localparam int COL_W = 8;

  typedef enum logic [1:0] {
    LEN_1 = 2'd0,
    LEN_2 = 2'd1,
    LEN_4 = 2'd2,
    LEN_8 = 2'd3
  } len_code_e;

  typedef struct packed {
    logic [COL_W-1:0] base;
    len_code_e        len;
    logic             xor_order;
    logic             wrap_row;
  } burst_cfg_t;
endpackage

// File: rtl/colburst_cfg.sv
module colburst_cfg
  import colburst_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] base_in,
  input  logic [1:0]    len_in,
  input  logic          xor_in,
  input  logic          wrap_in,
  output burst_cfg_t    cfg_q,
  output logic [CW-1:0] span_mask
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q.base      <= base_in;
      cfg_q.len       <= len_code_e'(len_in);
      cfg_q.xor_order <= xor_in;
      cfg_q.wrap_row  <= wrap_in;
    end
  end

  // span covers the low bits that wrap; the whole row in wrap mode
  always_comb begin
    if (cfg_q.wrap_row) span_mask = '1;
    else                span_mask = (ONE << cfg_q.len) - ONE;
  end
endmodule

// File: rtl/colburst_beat_ctr.sv
module colburst_beat_ctr #(
  parameter int CW = colburst_pkg::COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat <= '0;
    else if (clear) beat <= '0;
    else if (step)  beat <= beat + 1'b1;
  end
endmodule

// File: rtl/colburst_addr_map.sv
module colburst_addr_map #(
  parameter int CW     = colburst_pkg::COL_W,
  parameter bit XOR_EN = 1'b1
) (
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] beat,
  input  logic [CW-1:0] span_mask,
  input  logic          xor_order,
  input  logic          wrap_row,
  output logic [CW-1:0] addr
);
  logic [CW-1:0] lin_addr;

  // linear wrap: add within the span, keep the bits above it
  always_comb lin_addr = (base & ~span_mask) | ((base + beat) & span_mask);

  generate
    if (XOR_EN) begin : g_xor
      logic [CW-1:0] xor_addr;
      always_comb begin
        xor_addr = base ^ (beat & span_mask);
        addr     = (xor_order && !wrap_row) ? xor_addr : lin_addr;
      end
    end else begin : g_lin
      always_comb addr = lin_addr;
    end
  endgenerate
endmodule

// File: rtl/colburst_agen.sv
module colburst_agen
  import colburst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_col,
  input  logic [1:0] burst_len,
  input  logic       interleave,
  input  logic       full_page,
  input  logic       stop,
  input  logic       beat_ready,
  output logic       col_valid,
  output logic [7:0] col_addr,
  output logic       col_last,
  output logic       burst_done
);
  burst_cfg_t       cfg;
  logic [COL_W-1:0] span_mask;
  logic [COL_W-1:0] beat;
  logic             valid_q, done_q;
  logic             accept, final_beat, step;

  colburst_cfg #(.CW(COL_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(start),
    .base_in(start_col), .len_in(burst_len),
    .xor_in(interleave), .wrap_in(full_page),
    .cfg_q(cfg), .span_mask(span_mask)
  );

  always_comb begin
    accept     = valid_q & beat_ready;
    final_beat = valid_q & ~cfg.wrap_row & (beat == span_mask);
    step       = accept & ~final_beat & ~stop;
  end

  colburst_beat_ctr #(.CW(COL_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(step), .beat(beat)
  );

  colburst_addr_map #(.CW(COL_W), .XOR_EN(1'b1)) i_map (
    .base(cfg.base), .beat(beat), .span_mask(span_mask),
    .xor_order(cfg.xor_order), .wrap_row(cfg.wrap_row), .addr(col_addr)
  );

  // start wins over stop; stop wins over a natural finish
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= ~start & ~stop & accept & final_beat;
      if (start)                    valid_q <= 1'b1;
      else if (stop)                valid_q <= 1'b0;
      else if (accept & final_beat) valid_q <= 1'b0;
    end
  end

  assign col_valid  = valid_q;
  assign col_last   = final_beat;
  assign burst_done = done_q;
endmodule

// File: rtl/colburst_agen_chk.sv
module colburst_agen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] start_col,
  input logic       full_page,
  input logic       stop,
  input logic       beat_ready,
  input logic       col_valid,
  input logic [7:0] col_addr,
  input logic       col_last,
  input logic       burst_done
);
  logic row_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_mode <= 1'b0;
    else if (start) row_mode <= full_page;
  end

  // R2
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid);

  // R10
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_addr == $past(start_col));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !beat_ready && !start && !stop
      |=> col_valid && $stable(col_addr) && $stable(col_last));

  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !col_valid && !burst_done);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && beat_ready && col_last && !start && !stop |=> burst_done && !col_valid);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R8
  row_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_mode && col_valid |-> !col_last);
endmodule

bind colburst_agen colburst_agen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .full_page(full_page), .stop(stop), .beat_ready(beat_ready),
  .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
  .burst_done(burst_done)
);

// File: tb/test_colburst_agen.sv
module test_colburst_agen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [1:0] burst_len = '0;
  logic       interleave = 1'b0;
  logic       full_page = 1'b0;
  logic       stop = 1'b0;
  logic       beat_ready = 1'b0;
  logic       col_valid;
  logic [7:0] col_addr;
  logic       col_last;
  logic       burst_done;

  int n_checks = 0;
  int n_fails  = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  colburst_agen i_colburst_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .burst_len(burst_len), .interleave(interleave), .full_page(full_page),
    .stop(stop), .beat_ready(beat_ready), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] col, input int code,
                                          input bit il, input bit fp, input int k);
    logic [7:0] m;
    if (fp) return 8'(col + k);
    m = 8'((1 << code) - 1);
    if (il) return col ^ (8'(k) & m);
    return (col & ~m) | (8'(col + k) & m);
  endfunction

  // monitor: one expected item per accepted beat
  always @(negedge clk) begin
    if (rst_n && col_valid && beat_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected beat", col_addr, 0);
      end else begin
        logic [8:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({col_last, col_addr} == e, t, {col_last, col_addr}, e);
      end
    end
  end

  task automatic push_beats(input logic [7:0] col, input int code, input bit il,
                            input bit fp, input int n, input string tag);
    int bl;
    bl = 1 << code;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({(!fp && k == bl - 1), exp_addr(col, code, il, fp, k)});
      tag_q.push_back(tag);
    end
  endtask

  // R11: disturb the settings after they were captured
  task automatic scramble();
    start_col  = ~start_col;
    burst_len  = ~burst_len;
    interleave = ~interleave;
  endtask

  // called just after a rising edge; returns just after a rising edge
  task automatic run_bounded(input logic [7:0] col, input int code, input bit il,
                             input logic [7:0] pat, input string tag);
    int i = 0;
    push_beats(col, code, il, 1'b0, 1 << code, tag);
    start = 1'b1; start_col = col; burst_len = 2'(code); interleave = il;
    full_page = 1'b0; beat_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    scramble();
    while (exp_q.size() != 0 && i < 200) begin
      beat_ready = pat[i % 8];
      i++;
      @(posedge clk); #1;
    end
    check(col_valid == 1'b0, "R6 valid drop", col_valid, 0);
    check(burst_done == 1'b1, "R6 done pulse", burst_done, 1);
    @(posedge clk); #1;
    check(burst_done == 1'b0, "R6 done single", burst_done, 0);
  endtask

  task automatic run_cut(input logic [7:0] col, input int code, input bit il,
                         input bit fp, input int k, input bit do_stop, input string tag);
    push_beats(col, code, il, fp, k, tag);
    start = 1'b1; start_col = col; burst_len = 2'(code); interleave = il;
    full_page = fp; beat_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    scramble();
    repeat (k - 1) begin
      @(posedge clk); #1;
    end
    if (do_stop) begin
      stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0;
      check(col_valid == 1'b0, "R9 valid after stop", col_valid, 0);
      check(burst_done == 1'b0, "R9 no done after stop", burst_done, 0);
      check(exp_q.size() == 0, "R9 beats left", exp_q.size(), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(col_valid == 1'b0, "R1 valid in reset", col_valid, 0);
    check(burst_done == 1'b0, "R1 done in reset", burst_done, 0);
    check(col_last == 1'b0, "R1 last in reset", col_last, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(col_valid == 1'b0, "R1 valid after reset", col_valid, 0);

    // R2 R3 R5 R6: linear wrap, four beats
    run_bounded(8'h0E, 2, 1'b0, 8'hFF, "R3 lin BL4");
    // R3 R7 R11: linear eight beats with stalls
    run_bounded(8'h35, 3, 1'b0, 8'b1011_0101, "R7 lin BL8 stall");
    // R4
    run_bounded(8'h35, 3, 1'b1, 8'hFF, "R4 xor BL8");
    run_bounded(8'h42, 2, 1'b1, 8'b0110_1101, "R4 xor BL4 stall");
    // R5 single beat
    run_bounded(8'h99, 0, 1'b0, 8'hFF, "R5 BL1");
    run_bounded(8'hFF, 1, 1'b0, 8'hFF, "R3 lin BL2 top");
    run_bounded(8'hFE, 1, 1'b1, 8'b0010_0101, "R4 xor BL2");
    // R8 R9: row wrap past 255, xor request ignored
    run_cut(8'hFC, 3, 1'b1, 1'b1, 260, 1'b1, "R8 row wrap");
    run_cut(8'h80, 0, 1'b0, 1'b1, 1, 1'b1, "R8 row one beat");
    // R9 bounded burst cut short
    run_cut(8'h20, 3, 1'b0, 1'b0, 3, 1'b1, "R9 cut BL8");
    // R10 restart mid-burst
    run_cut(8'h10, 3, 1'b0, 1'b0, 3, 1'b0, "R10 first burst");
    run_bounded(8'h21, 2, 1'b1, 8'hFF, "R10 restarted burst");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule